// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache

This block is a direct-mapped data cache between a processor load/store port and a lower memory port that moves whole 16-byte blocks. Each line holds a tag, a valid flag, a modified flag and the block data. A processor access is split into tag, line index and byte offset. A hit completes in the cycle it is presented. A miss stalls the processor while the block is brought in and installed, and the access then completes as a hit.

Stores write into the cache only and mark the line modified. A store that misses allocates the block first and then merges its bytes. When a modified line is displaced, its block address and data move into a small FIFO write buffer, and the refill starts without waiting for the eviction to reach memory. A refill looks in the write buffer first. If the wanted block is still waiting there, the youngest copy supplies the line and no memory read is issued. The processor stalls on a modified victim only when the buffer has no free slot.

Top module: `wb_dm_cache`

## Requirements
- R1: An address is split as byte offset = bits [3:0], line index = bits [11:4] and tag = bits [31:12], giving 256 lines of 16 bytes. A block address presented on the memory ports is address bits [31:4].
- R2: An access hits only when the indexed line is valid and its stored tag equals the address tag. A hit raises `cpu_hit` with `cpu_stall` low in the same cycle. On a read hit, `cpu_rdata` carries the aligned 32-bit word that holds the addressed byte.
- R3: On a miss `cpu_stall` is high from the first cycle. A block read of the missing block address is requested, and once the block is installed with its tag and valid flag the held access completes as a hit.
- R4: A store hit changes only its enabled byte lanes, marks the line modified and causes no lower-memory write.
- R5: A store miss fetches the block first, then merges the store. The other bytes of the block keep their memory values.
- R6: A modified victim's block address and data enter the write buffer, and its refill proceeds while that write is still unaccepted. The buffer drains oldest first on `mem_wr_req`/`mem_wr_ack`, holding address and data stable until acknowledged.
- R7: If a miss needs to evict a modified line while the write buffer is full, the processor stays stalled and no block read is requested until a slot frees.
- R8: A clean or invalid victim is overwritten with no lower-memory write.
- R9: A refill of a block still held in the write buffer takes its data from the youngest matching buffer entry and issues no memory read.
- R10: Reset clears every valid and modified flag, so the first access to any line after reset misses.
- R11: `cpu_size` selects the byte lanes of a store. Code 0 selects one byte, the lane given by address bits [1:0]. Code 1 selects a halfword: lanes 0–1 when address bit 1 is 0, lanes 2–3 when it is 1. Codes 2 and 3 select the full word. `cpu_wdata` is given in lane position: byte lane k is bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access valid, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | Store width code |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data in lane position |
| cpu_rdata | output | 32 | Aligned load word |
| cpu_hit | output | 1 | Access hits this cycle |
| cpu_stall | output | 1 | Access cannot complete this cycle |
| mem_rd_req | output | 1 | Block read request, held until data returns |
| mem_rd_addr | output | 28 | Block address to read |
| mem_rd_valid | input | 1 | One-cycle pulse with the read block |
| mem_rd_data | input | 128 | Read block |
| mem_wr_req | output | 1 | Write buffer head is valid |
| mem_wr_addr | output | 28 | Block address of the buffer head |
| mem_wr_data | output | 128 | Block data of the buffer head |
| mem_wr_ack | input | 1 | Lower memory accepts the head entry |

## Verification
The bench holds the lower memory's acknowledge off, so evicted blocks are still queued when they are re-read. A design that fetched from memory there would return data from before the stores, and one that searched oldest-first would return an older store. It also fills the buffer with the acknowledge held and then forces another modified eviction. A design that ignored a full buffer would either drop a victim or start a read early. It checks that memory ends holding the last of three writes to one block, which catches a buffer draining out of order. Address splits, byte and halfword merges on store misses, and clean evictions that must not write are checked directly. Random mixes over a few conflicting lines check hit prediction and load data against a reference image.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WORD_ALT = 2'd3
   } acc_size_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_FILL = 1'b1
   } ctl_state_e;

   // Byte lanes touched by a store within one 32-bit word.
   function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] lo);
      logic [3:0] m;
      case (acc_size_e'(size))
         SZ_BYTE: m = 4'b0001 << lo;
         SZ_HALF: m = lo[1] ? 4'b1100 : 4'b0011;
         default: m = 4'b1111;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/wbc_addr_split.sv
module wbc_addr_split #(
   parameter int ADDR_W   = 32,
   parameter int OFFSET_W = 4,
   parameter int INDEX_W  = 8
) (
   input  logic [ADDR_W-1:0]                  addr,
   output logic [ADDR_W-INDEX_W-OFFSET_W-1:0] tag,
   output logic [INDEX_W-1:0]                 index,
   output logic [OFFSET_W-1:0]                offset
);
   localparam int TAG_LSB = OFFSET_W + INDEX_W;

   assign offset = addr[OFFSET_W-1:0];
   assign index  = addr[TAG_LSB-1:OFFSET_W];
   assign tag    = addr[ADDR_W-1:TAG_LSB];
endmodule

// File: rtl/wbc_line_store.sv
module wbc_line_store #(
   parameter int INDEX_W    = 8,
   parameter int TAG_W      = 20,
   parameter int LINE_BYTES = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [INDEX_W-1:0]      idx,
   output logic                    line_valid,
   output logic                    line_dirty,
   output logic [TAG_W-1:0]        line_tag,
   output logic [LINE_BYTES*8-1:0] line_data,
   input  logic                    fill_en,
   input  logic [TAG_W-1:0]        fill_tag,
   input  logic [LINE_BYTES*8-1:0] fill_data,
   input  logic                    st_en,
   input  logic [LINE_BYTES-1:0]   st_be,
   input  logic [LINE_BYTES*8-1:0] st_data
);
   localparam int LINES     = 1 << INDEX_W;
   localparam int LINE_BITS = LINE_BYTES * 8;

   logic [LINE_BITS-1:0] data_q [LINES];
   logic [TAG_W-1:0]     tag_q  [LINES];
   logic [LINES-1:0]     valid_q;
   logic [LINES-1:0]     dirty_q;
   logic [LINE_BITS-1:0] nxt_line;

   assign line_valid = valid_q[idx];
   assign line_dirty = dirty_q[idx];
   assign line_tag   = tag_q[idx];
   assign line_data  = data_q[idx];

   // Per-byte merge: a refill replaces the whole line, a store only its lanes.
   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_merge
      assign nxt_line[b*8 +: 8] = fill_en   ? fill_data[b*8 +: 8] :
                                  st_be[b]  ? st_data[b*8 +: 8]   :
                                              line_data[b*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (fill_en || st_en) data_q[idx] <= nxt_line;
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[idx] <= fill_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_en) begin
         valid_q[idx] <= 1'b1;
         dirty_q[idx] <= 1'b0;
      end else if (st_en) begin
         dirty_q[idx] <= 1'b1;
      end
   end
endmodule

// File: rtl/wbc_wbuf.sv
module wbc_wbuf #(
   parameter int DEPTH  = 2,
   parameter int AW     = 28,
   parameter int DW     = 128
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   output logic          full,
   output logic          head_valid,
   output logic [AW-1:0] head_addr,
   output logic [DW-1:0] head_data,
   input  logic          pop,
   input  logic [AW-1:0] look_addr,
   output logic          look_hit,
   output logic [DW-1:0] look_data
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0]            cnt_q;
   logic [CNT_W-1:0]            wr_slot;
   logic [DEPTH-1:0][AW-1:0]    addr_v;
   logic [DEPTH-1:0][DW-1:0]    data_v;

   assign full       = (cnt_q == CNT_W'(DEPTH));
   assign head_valid = (cnt_q != '0);
   assign head_addr  = addr_v[0];
   assign head_data  = data_v[0];
   assign wr_slot    = pop ? cnt_q - CNT_W'(1) : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
   end

   // Slot 0 is the oldest entry; a pop shifts every slot down by one.
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [AW-1:0] a_q;
      logic [DW-1:0] d_q;
      logic [AW-1:0] up_a;
      logic [DW-1:0] up_d;
      if (i < DEPTH - 1) begin : g_mid
         assign up_a = g_slot[i+1].a_q;
         assign up_d = g_slot[i+1].d_q;
      end else begin : g_top
         assign up_a = '0;
         assign up_d = '0;
      end
      always_ff @(posedge clk) begin
         if (push && wr_slot == CNT_W'(i)) begin
            a_q <= push_addr;
            d_q <= push_data;
         end else if (pop) begin
            a_q <= up_a;
            d_q <= up_d;
         end
      end
      assign addr_v[i] = a_q;
      assign data_v[i] = d_q;
   end

   // Search oldest to youngest so that the youngest match is the one kept.
   always_comb begin
      look_hit  = 1'b0;
      look_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (CNT_W'(i) < cnt_q && addr_v[i] == look_addr) begin
            look_hit  = 1'b1;
            look_data = data_v[i];
         end
      end
   end
endmodule

// File: rtl/wb_dm_cache.sv
module wb_dm_cache
   import wbc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int OFFSET_W   = 4,
   parameter int INDEX_W    = 8,
   parameter int WORD_W     = 32,
   parameter int WBUF_DEPTH = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cpu_req,
   input  logic                        cpu_we,
   input  logic [1:0]                  cpu_size,
   input  logic [ADDR_W-1:0]           cpu_addr,
   input  logic [WORD_W-1:0]           cpu_wdata,
   output logic [WORD_W-1:0]           cpu_rdata,
   output logic                        cpu_hit,
   output logic                        cpu_stall,
   output logic                        mem_rd_req,
   output logic [ADDR_W-OFFSET_W-1:0]  mem_rd_addr,
   input  logic                        mem_rd_valid,
   input  logic [(8<<OFFSET_W)-1:0]    mem_rd_data,
   output logic                        mem_wr_req,
   output logic [ADDR_W-OFFSET_W-1:0]  mem_wr_addr,
   output logic [(8<<OFFSET_W)-1:0]    mem_wr_data,
   input  logic                        mem_wr_ack
);
   localparam int TAG_W      = ADDR_W - INDEX_W - OFFSET_W;
   localparam int BLK_W      = ADDR_W - OFFSET_W;
   localparam int LINE_BYTES = 1 << OFFSET_W;
   localparam int LINE_BITS  = LINE_BYTES * 8;
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int WORDS      = LINE_BITS / WORD_W;

   // Elaboration-time parameter checks.
   if (WORD_W != 32) begin : g_chk_word
      $error("wb_dm_cache: WORD_W must be 32");
   end
   if (OFFSET_W < 2) begin : g_chk_off
      $error("wb_dm_cache: a line must hold at least one word");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("wb_dm_cache: no tag bits left");
   end
   if (WBUF_DEPTH < 1) begin : g_chk_wb
      $error("wb_dm_cache: write buffer needs at least one slot");
   end

   logic [TAG_W-1:0]      a_tag;
   logic [INDEX_W-1:0]    a_index;
   logic [OFFSET_W-1:0]   a_off;

   ctl_state_e            state_q;
   logic [BLK_W-1:0]      miss_blk_q;

   logic [INDEX_W-1:0]    ls_idx;
   logic                  s_valid, s_dirty;
   logic [TAG_W-1:0]      s_tag;
   logic [LINE_BITS-1:0]  s_line;

   logic                  in_idle, lookup_hit, need_fill, victim_dirty, go_fill;
   logic                  fill_en, st_en;
   logic [LINE_BITS-1:0]  fill_line;
   logic [LINE_BYTES-1:0] st_be;
   logic [3:0]            lanes;

   logic                  wb_push, wb_full, wb_head_valid, wb_pop, fwd_hit;
   logic [LINE_BITS-1:0]  fwd_data;

   wbc_addr_split #(
      .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W)
   ) u_split (
      .addr(cpu_addr), .tag(a_tag), .index(a_index), .offset(a_off)
   );

   assign in_idle      = (state_q == ST_IDLE);
   assign ls_idx       = in_idle ? a_index : miss_blk_q[INDEX_W-1:0];
   assign lookup_hit   = s_valid && (s_tag == a_tag);
   assign cpu_hit      = cpu_req && in_idle && lookup_hit;
   assign cpu_stall    = cpu_req && !cpu_hit;
   assign need_fill    = cpu_req && in_idle && !lookup_hit;
   assign victim_dirty = s_valid && s_dirty;
   assign go_fill      = need_fill && (!victim_dirty || !wb_full);
   assign wb_push      = go_fill && victim_dirty;

   assign mem_rd_req   = !in_idle && !fwd_hit;
   assign mem_rd_addr  = miss_blk_q;
   assign fill_en      = !in_idle && (fwd_hit || mem_rd_valid);
   assign fill_line    = fwd_hit ? fwd_data : mem_rd_data;
   assign st_en        = cpu_hit && cpu_we;
   assign lanes        = lane_mask(cpu_size, a_off[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         miss_blk_q <= '0;
      end else if (in_idle) begin
         if (go_fill) begin
            state_q    <= ST_FILL;
            miss_blk_q <= {a_tag, a_index};
         end
      end else if (fill_en) begin
         state_q <= ST_IDLE;
      end
   end

   // Word selection inside the line; a one-word line needs no selector.
   if (WORDS == 1) begin : g_one_word
      assign cpu_rdata = s_line;
      assign st_be     = lanes;
   end else begin : g_multi_word
      logic [OFFSET_W-3:0] wsel;
      assign wsel      = a_off[OFFSET_W-1:2];
      assign cpu_rdata = s_line[wsel*WORD_W +: WORD_W];
      for (genvar w = 0; w < WORDS; w++) begin : g_be
         assign st_be[w*WORD_BYTES +: WORD_BYTES] =
            (wsel == (OFFSET_W-2)'(w)) ? lanes : '0;
      end
   end

   wbc_line_store #(
      .INDEX_W(INDEX_W), .TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES)
   ) u_lines (
      .clk(clk), .rst_n(rst_n), .idx(ls_idx),
      .line_valid(s_valid), .line_dirty(s_dirty), .line_tag(s_tag), .line_data(s_line),
      .fill_en(fill_en), .fill_tag(miss_blk_q[BLK_W-1:INDEX_W]), .fill_data(fill_line),
      .st_en(st_en), .st_be(st_be), .st_data({WORDS{cpu_wdata}})
   );

   assign wb_pop     = mem_wr_ack && wb_head_valid;
   assign mem_wr_req = wb_head_valid;

   wbc_wbuf #(
      .DEPTH(WBUF_DEPTH), .AW(BLK_W), .DW(LINE_BITS)
   ) u_wbuf (
      .clk(clk), .rst_n(rst_n),
      .push(wb_push), .push_addr({s_tag, a_index}), .push_data(s_line),
      .full(wb_full), .head_valid(wb_head_valid),
      .head_addr(mem_wr_addr), .head_data(mem_wr_data),
      .pop(wb_pop),
      .look_addr(miss_blk_q), .look_hit(fwd_hit), .look_data(fwd_data)
   );
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
   parameter int BLK_W     = 28,
   parameter int LINE_BITS = 128
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cpu_req,
   input logic                 cpu_hit,
   input logic                 cpu_stall,
   input logic                 mem_rd_req,
   input logic                 mem_rd_valid,
   input logic                 mem_wr_req,
   input logic                 mem_wr_ack,
   input logic [BLK_W-1:0]     mem_wr_addr,
   input logic [LINE_BITS-1:0] mem_wr_data,
   input logic                 wb_push,
   input logic                 wb_full
);
   assert_hit_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hit |-> (cpu_req && !cpu_stall));

   assert_fetch_blocks_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !cpu_hit);

   assert_fill_drops_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && mem_rd_req) |=> !mem_rd_req);

   assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && !mem_wr_ack) |=>
         (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_push |-> !wb_full);
endmodule

bind wb_dm_cache wbc_checker #(
   .BLK_W(ADDR_W - OFFSET_W), .LINE_BITS(8 << OFFSET_W)
) u_wbc_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
   .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid),
   .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack),
   .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
   .wb_push(wb_push), .wb_full(wb_full)
);

// File: tb/wb_dm_cache_bench.sv
module wb_dm_cache_bench;
   localparam int RD_LAT = 3;
   localparam int NBLK   = 1024;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_req = 1'b0, cpu_we = 1'b0;
   logic [1:0]   cpu_size = 2'd2;
   logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
   logic [31:0]  cpu_rdata;
   logic         cpu_hit, cpu_stall;
   logic         mem_rd_req, mem_rd_valid;
   logic [27:0]  mem_rd_addr, mem_wr_addr;
   logic [127:0] mem_rd_data, mem_wr_data;
   logic         mem_wr_req, mem_wr_ack;

   always #2.5 clk = ~clk;

   wb_dm_cache u_wb_dm_cache (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
      .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
   );

   function automatic logic [127:0] blk_init(input int b);
      logic [127:0] v;
      for (int w = 0; w < 4; w++)
         v[w*32 +: 32] = (32'(b) * 32'h0001_0001) ^ (32'(w) * 32'h0F0F_0101) ^ 32'h5A5A_0000;
      return v;
   endfunction

   function automatic logic [3:0] exp_lanes(input logic [1:0] sz, input logic [1:0] lo);
      if (sz == 2'd0) return 4'b0001 << lo;
      if (sz == 2'd1) return lo[1] ? 4'b1100 : 4'b0011;
      return 4'b1111;
   endfunction

   // Lower memory model
   logic [127:0] lower [NBLK];
   logic         wr_block = 1'b0;
   int           rd_cnt_down, rd_count, wr_count;
   logic [27:0]  rd_hold, last_rd_addr, last_wr_addr;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NBLK; b++) lower[b] <= blk_init(b);
         mem_rd_valid <= 1'b0; mem_rd_data <= '0; mem_wr_ack <= 1'b0;
         rd_cnt_down <= 0; rd_count <= 0; wr_count <= 0;
         rd_hold <= '0; last_rd_addr <= '0; last_wr_addr <= '0;
      end else begin
         if (mem_rd_valid) mem_rd_valid <= 1'b0;
         else if (rd_cnt_down == 1) begin
            mem_rd_valid <= 1'b1; mem_rd_data <= lower[rd_hold[9:0]]; rd_cnt_down <= 0;
         end else if (rd_cnt_down > 1) rd_cnt_down <= rd_cnt_down - 1;
         else if (mem_rd_req) begin
            rd_cnt_down <= RD_LAT; rd_hold <= mem_rd_addr;
            rd_count <= rd_count + 1; last_rd_addr <= mem_rd_addr;
         end
         if (mem_wr_ack) mem_wr_ack <= 1'b0;
         else if (mem_wr_req && !wr_block) begin
            mem_wr_ack <= 1'b1; lower[mem_wr_addr[9:0]] <= mem_wr_data;
            wr_count <= wr_count + 1; last_wr_addr <= mem_wr_addr;
         end
      end
   end

   // Reference image and direct-mapped presence mirror
   logic [127:0] ref_blk [NBLK];
   logic [255:0] mir_valid;
   logic [19:0]  mir_tag [256];
   int n_checks = 0, n_fail = 0;

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int b = 0; b < NBLK; b++) ref_blk[b] = blk_init(b);
      mir_valid = '0;
   endtask

   task automatic do_access(input logic we, input logic [1:0] sz, input logic [31:0] addr,
                            input logic [31:0] wd, output logic [31:0] rd,
                            output logic first_hit, output int cyc);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = addr; cpu_wdata = wd;
      #1;
      first_hit = cpu_hit; cyc = 0;
      while (cpu_stall) begin
         @(negedge clk); #1; cyc++;
      end
      rd = cpu_rdata;
      @(posedge clk); #1;
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic ref_apply(input logic we, input logic [1:0] sz, input logic [31:0] addr,
                            input logic [31:0] wd);
      logic [3:0] ln;
      int blk;
      blk = int'(addr[13:4]);
      if (we) begin
         ln = exp_lanes(sz, addr[1:0]);
         for (int l = 0; l < 4; l++)
            if (ln[l]) ref_blk[blk][addr[3:2]*32 + l*8 +: 8] = wd[l*8 +: 8];
      end
      mir_valid[addr[11:4]] = 1'b1;
      mir_tag[addr[11:4]]   = addr[31:12];
   endtask

   task automatic checked_access(input string req, input logic we, input logic [1:0] sz,
                                 input logic [31:0] addr, input logic [31:0] wd,
                                 output logic [31:0] rd);
      logic exp_hit, fh;
      int   cyc;
      exp_hit = mir_valid[addr[11:4]] && (mir_tag[addr[11:4]] == addr[31:12]);
      do_access(we, sz, addr, wd, rd, fh, cyc);
      check({req, " R2 hit"}, 128'(fh), 128'(exp_hit));
      if (!exp_hit) check({req, " R3 miss stalls"}, 128'(cyc > 0), 128'(1));
      if (!we) check({req, " R2 load data"}, 128'(rd),
                     128'(ref_blk[int'(addr[13:4])][addr[3:2]*32 +: 32]));
      ref_apply(we, sz, addr, wd);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      #750000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int rc0, wc0;
      void'($urandom(32'd7351));
      model_reset();
      wait_cyc(4);
      // R10: reset state at the ports
      check("R10 stall idle", 128'(cpu_stall), 128'(0));
      check("R10 no read", 128'(mem_rd_req), 128'(0));
      check("R10 no write", 128'(mem_wr_req), 128'(0));
      rst_n = 1'b1;
      wait_cyc(2);

      // R1: address split; tag 3, index 0x8A, offset 0xC
      checked_access("R10 first access", 1'b0, 2'd2, 32'h0000_38AC, 32'h0, rd);
      check("R1 block address", 128'(last_rd_addr), 128'(28'h0000_38A));
      check("R1 word select", 128'(rd), 128'(blk_init(32'h38A) >> 96));
      checked_access("R1 same block", 1'b0, 2'd2, 32'h0000_38A0, 32'h0, rd);
      checked_access("R1 other tag", 1'b0, 2'd2, 32'h0000_18A4, 32'h0, rd);
      checked_access("R1 other index", 1'b0, 2'd2, 32'h0000_18B4, 32'h0, rd);

      // R5 and R11: byte and halfword store misses merge into the fetched block
      checked_access("R5 byte store miss", 1'b1, 2'd0, 32'h0000_0405, 32'hAABB_CCDD, rd);
      checked_access("R11 byte merge", 1'b0, 2'd2, 32'h0000_0404, 32'h0, rd);
      checked_access("R5 half store miss", 1'b1, 2'd1, 32'h0000_050A, 32'h1234_5678, rd);
      checked_access("R11 half merge", 1'b0, 2'd2, 32'h0000_0508, 32'h0, rd);

      // R4: store hit on a clean line writes nothing below
      checked_access("R4 load", 1'b0, 2'd2, 32'h0000_0600, 32'h0, rd);
      wc0 = wr_count;
      checked_access("R4 store hit", 1'b1, 2'd3, 32'h0000_0604, 32'hCAFE_F00D, rd);
      checked_access("R4 readback", 1'b0, 2'd2, 32'h0000_0604, 32'h0, rd);
      wait_cyc(6);
      check("R4 no memory write", 128'(wr_count), 128'(wc0));
      check("R4 write port idle", 128'(mem_wr_req), 128'(0));

      // R8: clean victim overwritten silently
      checked_access("R8 load A", 1'b0, 2'd2, 32'h0000_0140, 32'h0, rd);
      wc0 = wr_count;
      checked_access("R8 load B", 1'b0, 2'd2, 32'h0000_1140, 32'h0, rd);
      wait_cyc(6);
      check("R8 no write", 128'(wr_count), 128'(wc0));

      // R6: dirty victim queued, refill not waiting for it
      wr_block = 1'b1;
      checked_access("R6 store A", 1'b1, 2'd2, 32'h0000_0158, 32'h1357_9BDF, rd);
      wc0 = wr_count;
      checked_access("R6 load B", 1'b0, 2'd2, 32'h0000_1150, 32'h0, rd);
      check("R6 write pending after refill", 128'(mem_wr_req), 128'(1));
      check("R6 nothing written yet", 128'(wr_count), 128'(wc0));
      wr_block = 1'b0;
      wait_cyc(6);
      check("R6 one write", 128'(wr_count), 128'(wc0 + 1));
      check("R6 victim address", 128'(last_wr_addr), 128'(28'h0000_015));
      check("R6 victim data", 128'(lower[10'h015] >> 64), 128'(ref_blk[10'h015] >> 64));

      // R9: refill served from the write buffer, youngest entry first
      wr_block = 1'b1;
      checked_access("R9 store X1", 1'b1, 2'd2, 32'h0000_01E0, 32'h1111_0001, rd);
      checked_access("R9 evict A", 1'b0, 2'd2, 32'h0000_11E0, 32'h0, rd);
      rc0 = rd_count;
      checked_access("R9 forward X1", 1'b0, 2'd2, 32'h0000_01E0, 32'h0, rd);
      check("R9 no read for buffered block", 128'(rd_count), 128'(rc0));
      check("R9 memory still stale", 128'(lower[10'h01E][31:0] != 32'h1111_0001), 128'(1));
      checked_access("R9 store X2", 1'b1, 2'd2, 32'h0000_01E0, 32'h2222_0002, rd);
      checked_access("R9 evict A again", 1'b0, 2'd2, 32'h0000_11E0, 32'h0, rd);
      rc0 = rd_count;
      checked_access("R9 forward youngest", 1'b0, 2'd2, 32'h0000_01E0, 32'h0, rd);
      check("R9 youngest no read", 128'(rd_count), 128'(rc0));

      // R7: buffer full, dirty eviction must wait without reading
      checked_access("R7 store X3", 1'b1, 2'd2, 32'h0000_01E0, 32'h3333_0003, rd);
      wc0 = wr_count;
      rc0 = rd_count;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_size = 2'd2; cpu_addr = 32'h0000_11E4;
      wait_cyc(8);
      #1;
      check("R7 still stalled", 128'(cpu_stall), 128'(1));
      check("R7 no read issued", 128'(rd_count), 128'(rc0));
      check("R7 read port idle", 128'(mem_rd_req), 128'(0));
      wr_block = 1'b0;
      while (cpu_stall) begin @(negedge clk); #1; end
      check("R7 load after release", 128'(cpu_rdata), 128'(ref_blk[10'h11E][63:32]));
      @(posedge clk); #1; cpu_req = 1'b0;
      ref_apply(1'b0, 2'd2, 32'h0000_11E4, 32'h0);
      wait_cyc(20);
      check("R6 three writes in order", 128'(wr_count), 128'(wc0 + 3));
      check("R6 last write wins", 128'(lower[10'h01E][31:0]), 128'(32'h3333_0003));

      // Random mix over a few conflicting lines
      for (int n = 0; n < 600; n++) begin
         logic [31:0] a;
         logic [1:0]  sz;
         logic        we;
         int          pick;
         pick = int'($urandom % 6);
         a = {18'h0, 2'($urandom % 4), 12'h0};
         case (pick)
            0: a[11:4] = 8'h00;
            1: a[11:4] = 8'h07;
            2: a[11:4] = 8'h08;
            3: a[11:4] = 8'hC8;
            4: a[11:4] = 8'hFF;
            default: a[11:4] = 8'h15;
         endcase
         a[3:0] = 4'($urandom);
         sz = 2'($urandom % 4);
         we = ($urandom % 3) == 0;
         if (we) begin
            if (sz == 2'd1) a[0] = 1'b0;
            else if (sz[1]) a[1:0] = 2'b00;
         end else a[1:0] = 2'b00;
         checked_access(we ? "R11 random store" : "R2 random load", we, sz, a, $urandom, rd);
      end

      // R10: reset again empties the cache
      @(negedge clk); rst_n = 1'b0;
      model_reset();
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      checked_access("R10 miss after reset", 1'b0, 2'd2, 32'h0000_38AC, 32'h0, rd);
      checked_access("R10 miss other line", 1'b0, 2'd2, 32'h0000_0150, 32'h0, rd);

      wait_cyc(5);
      summary();
      $finish;
   end
endmodule